// File: doc/BRIEF.md
# Dual-role USB controller interrupt and control register file

This block is the software-visible register file of a dual-role USB controller. A 32-bit bus with byte address, write strobe, write data and combinational read data reaches five words: a control word, a PHY-control word, an interrupt-enable word, an interrupt-flag word and a read-only live status word. The block does not contain the role state machine, the analog comparators or the PHY. It only watches their outputs.

Five line levels come in already synchronized: ID, session end, B-valid, A-valid and VBUS-valid. A sticky flag is raised whenever any of them toggles, in either direction. An external role state machine sends eight one-cycle event pulses, and each pulse raises its own sticky flag. Software clears a flag by writing 1 to its bit. The single interrupt line is the registered OR of all enabled flags. Two control bits are also cleared by hardware events: the bus-request bit and the HNP-request-enable bit.

Top module: `dualrole_csr`

## Requirements
- R1: During and after reset, every writable word and every flag reads 0 and `irq_o` is 0. Line levels held steady through reset raise no change flag when reset is released.
- R2: Byte offsets are 0x00 control, 0x04 PHY control, 0x08 interrupt enable, 0x0C interrupt flags and 0x10 live status. Control keeps bits 0,1,2,4,5. PHY control keeps bits 0,1,4,5. Every other offset reads 0, and writes to it have no effect.
- R3: A change of `line_i` in either direction, sampled at a clock edge, sets a flag at that edge. The mapping is `line_i[0]` (ID) to flag bit 5, `line_i[1]` (session end) to bit 11, `line_i[2]` (B-valid) to bit 8, `line_i[3]` (A-valid) to bit 9 and `line_i[4]` (VBUS-valid) to bit 10.
- R4: A high `evt_i[k]` at a clock edge sets a flag. For k = 0..7 the flag bits are 0, 1, 2, 3, 4, 6, 7 and 13. These stand for role change, VBUS error, SRP fail, HNP fail, went idle, became peripheral, became host and SRP detected.
- R5: Writing 1 to a flag bit at 0x0C clears it, and writing 0 leaves it unchanged. If a set and a clear reach the same bit at the same edge, the bit stays set.
- R6: The enable word uses the flag bit positions. Bits 12 and 14–31 of the enable and flag words read 0 and ignore writes.
- R7: A control write with bit 0 (VBUS drop) set leaves bit 1 (bus request) at 0, whatever bit 1 of the write data holds.
- R8: A toggle of the ID line clears bus request (control bit 1) at the same edge that sets flag bit 5. This takes priority over a control write in the same cycle.
- R9: A pulse on `hnp_clr_i` clears control bit 2 (HNP request enable). This takes priority over a control write in the same cycle.
- R10: `irq_o` is a register. One cycle after any flag bit and its enable bit are both 1 it is high, and otherwise it is low.
- R11: Reading 0x10 returns the live inputs: bit 0 over-current, bits 1–5 `line_i[0..4]`, bit 6 acting as peripheral, bit 7 acting as host, and 0 above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_i | input | 5 | Synchronized levels: ID, session end, B-valid, A-valid, VBUS-valid |
| overcur_i | input | 1 | Over-current level from the role logic |
| as_peri_i | input | 1 | Device currently acts as peripheral |
| as_host_i | input | 1 | Device currently acts as host |
| evt_i | input | 8 | One-cycle event pulses from the role state machine |
| hnp_clr_i | input | 1 | Pulse: role transition or return to idle |
| ctl_o | output | 6 | Current control word bits 5..0 |
| phy_o | output | 6 | Current PHY-control word bits 5..0 |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest situations to reach are collisions: a hardware set meeting a software clear on the same flag at the same edge, and a hardware clear of a control bit meeting a software write to that bit. The stimulus drives an event pulse in the same cycle as a write-1-clear of its flag. It also toggles the ID line, and pulses the HNP clear input, in the same cycle as control writes that try to set the bits being cleared. A behavioural model updated at each edge is compared with the outputs and the addressed read word on every cycle. Line levels are held non-zero across reset to confirm that releasing reset raises no spurious change flag.

// File: rtl/dualrole_csr_pkg.sv
`timescale 1ns/1ps
// Package: shared constants for the dual-role USB register file.
// Assumes byte addressing with word-aligned offsets.
package dualrole_csr_pkg;
    localparam int DW       = 32;
    localparam int NLINE    = 5;
    localparam int NEVT     = 8;
    localparam int CTL_W    = 6;

    localparam int OFF_CTL  = 'h00;
    localparam int OFF_PHY  = 'h04;
    localparam int OFF_IEN  = 'h08;
    localparam int OFF_FLG  = 'h0C;
    localparam int OFF_LIVE = 'h10;

    localparam logic [CTL_W-1:0] CTL_MASK = 6'h37;
    localparam logic [CTL_W-1:0] PHY_MASK = 6'h33;
    localparam logic [DW-1:0]    FLG_MASK = 32'h0000_2FFF;

    localparam int BIT_DROP   = 0;
    localparam int BIT_BUSREQ = 1;
    localparam int BIT_HNPEN  = 2;

    // flag bit raised by each event pulse
    localparam int EVT_POS  [NEVT]  = '{0, 1, 2, 3, 4, 6, 7, 13};
    // flag bit raised by a toggle of each line
    localparam int LINE_POS [NLINE] = '{5, 11, 8, 9, 10};
endpackage

// File: rtl/dualrole_csr_edge.sv
`timescale 1ns/1ps
// Module: toggle detector for a vector of synchronized levels.
// Samples the levels on every edge, including edges in reset, so the
// first comparison after reset is against the level held during reset.
// Assumes the inputs are already synchronous to clk.
module dualrole_csr_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] tog_o
);
    logic [N-1:0] prev_q;

    // remember last sampled level (reset needs no special value)
    always_ff @(posedge clk) begin
        prev_q <= lvl_i;
    end

    // any difference is a toggle in either direction
    always_comb begin
        tog_o = lvl_i ^ prev_q;
    end
endmodule

// File: rtl/dualrole_csr_flags.sv
`timescale 1ns/1ps
// Module: sticky flag bank, write-1-to-clear, set beats clear.
// Only bits with MASK set get a flop; other bits are tied to 0.
module dualrole_csr_flags #(
    parameter int          W    = 32,
    parameter logic [W-1:0] MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        if (MASK[g]) begin : g_impl
            logic q;
            // hold flag: set has priority so no event is lost
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= 1'b0;
                else if (set_i[g]) q <= 1'b1;
                else if (clr_i[g]) q <= 1'b0;
            end
            assign q_o[g] = q;
        end else begin : g_rsvd
            assign q_o[g] = 1'b0;
        end
    end
endmodule

// File: rtl/dualrole_csr_ctl.sv
`timescale 1ns/1ps
// Module: control, PHY-control and interrupt-enable words.
// Control bit 1 (bus request) and bit 2 (HNP enable) are also cleared by
// hardware; hardware clears win over a write in the same cycle.
module dualrole_csr_ctl
    import dualrole_csr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ctl_i,
    input  logic             wr_phy_i,
    input  logic             wr_ien_i,
    input  logic [DW-1:0]    wdata_i,
    input  logic             id_tog_i,
    input  logic             hnp_clr_i,
    output logic [CTL_W-1:0] ctl_o,
    output logic [CTL_W-1:0] phy_o,
    output logic [DW-1:0]    ien_o
);
    logic [CTL_W-1:0] ctl_q, ctl_d, phy_q;
    logic [DW-1:0]    ien_q;

    // next control value: software write, then hardware clears on top
    always_comb begin
        ctl_d = ctl_q;
        if (wr_ctl_i) begin
            ctl_d = wdata_i[CTL_W-1:0] & CTL_MASK;
            if (wdata_i[BIT_DROP]) ctl_d[BIT_BUSREQ] = 1'b0;
        end
        if (id_tog_i)  ctl_d[BIT_BUSREQ] = 1'b0;
        if (hnp_clr_i) ctl_d[BIT_HNPEN]  = 1'b0;
    end

    // register the three writable words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            phy_q <= '0;
            ien_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            if (wr_phy_i) phy_q <= wdata_i[CTL_W-1:0] & PHY_MASK;
            if (wr_ien_i) ien_q <= wdata_i & FLG_MASK;
        end
    end

    assign ctl_o = ctl_q;
    assign phy_o = phy_q;
    assign ien_o = ien_q;
endmodule

// File: rtl/dualrole_csr.sv
`timescale 1ns/1ps
// Module: dual-role USB interrupt and control register file (top).
// Decodes a simple read/write bus, latches line toggles and role events as
// sticky flags, and drives a registered interrupt. Inputs are synchronous.
module dualrole_csr
    import dualrole_csr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [NLINE-1:0]  line_i,
    input  logic              overcur_i,
    input  logic              as_peri_i,
    input  logic              as_host_i,
    input  logic [NEVT-1:0]   evt_i,
    input  logic              hnp_clr_i,
    output logic [CTL_W-1:0]  ctl_o,
    output logic [CTL_W-1:0]  phy_o,
    output logic              irq_o
);
    logic             sel_ctl, sel_phy, sel_ien, sel_flg, sel_live;
    logic [NLINE-1:0] tog;
    logic [DW-1:0]    set_v, clr_v, sts_q, en_q, live_w;
    logic             irq_q;

    // address decode
    always_comb begin
        sel_ctl  = (bus_addr == ADDR_W'(OFF_CTL));
        sel_phy  = (bus_addr == ADDR_W'(OFF_PHY));
        sel_ien  = (bus_addr == ADDR_W'(OFF_IEN));
        sel_flg  = (bus_addr == ADDR_W'(OFF_FLG));
        sel_live = (bus_addr == ADDR_W'(OFF_LIVE));
    end

    dualrole_csr_edge #(.N(NLINE)) edge_i (
        .clk   (clk),
        .lvl_i (line_i),
        .tog_o (tog)
    );

    // gather hardware set requests into flag positions
    always_comb begin
        set_v = '0;
        for (int i = 0; i < NEVT; i++)  set_v[EVT_POS[i]]  = set_v[EVT_POS[i]]  | evt_i[i];
        for (int i = 0; i < NLINE; i++) set_v[LINE_POS[i]] = set_v[LINE_POS[i]] | tog[i];
        clr_v = (bus_we && sel_flg) ? bus_wdata : '0;
    end

    dualrole_csr_flags #(.W(DW), .MASK(FLG_MASK)) flags_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (set_v),
        .clr_i (clr_v),
        .q_o   (sts_q)
    );

    dualrole_csr_ctl ctl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctl_i  (bus_we && sel_ctl),
        .wr_phy_i  (bus_we && sel_phy),
        .wr_ien_i  (bus_we && sel_ien),
        .wdata_i   (bus_wdata),
        .id_tog_i  (tog[0]),
        .hnp_clr_i (hnp_clr_i),
        .ctl_o     (ctl_o),
        .phy_o     (phy_o),
        .ien_o     (en_q)
    );

    // live status word
    always_comb begin
        live_w = '0;
        live_w[0]       = overcur_i;
        live_w[NLINE:1] = line_i;
        live_w[6]       = as_peri_i;
        live_w[7]       = as_host_i;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        if (sel_ctl)  bus_rdata[CTL_W-1:0] = ctl_o;
        if (sel_phy)  bus_rdata[CTL_W-1:0] = phy_o;
        if (sel_ien)  bus_rdata = en_q;
        if (sel_flg)  bus_rdata = sts_q;
        if (sel_live) bus_rdata = live_w;
    end

    // registered interrupt request
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |(sts_q & en_q);
    end
    assign irq_o = irq_q;
endmodule

// File: rtl/dualrole_csr_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to dualrole_csr.
module dualrole_csr_chk
    import dualrole_csr_pkg::*;
#(
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [DW-1:0]     bus_wdata,
    input logic [NLINE-1:0]  line_i,
    input logic [NEVT-1:0]   evt_i,
    input logic              hnp_clr_i,
    input logic [CTL_W-1:0]  ctl_o,
    input logic              irq_o,
    input logic [DW-1:0]     sts_q,
    input logic [DW-1:0]     en_q
);
    p_line_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_i[2]) |=> sts_q[8]);
    p_evt_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[7] |=> sts_q[13]);
    p_w1c_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_FLG) && bus_wdata[3] && !evt_i[3]) |=> !sts_q[3]);
    p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[0] |=> sts_q[0]);
    p_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(OFF_CTL) && bus_wdata[0]) |=> !ctl_o[1]);
    p_id_busreq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(line_i[0]) |=> (!ctl_o[1] && sts_q[5]));
    p_hnp_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hnp_clr_i |=> !ctl_o[2]);
    p_irq_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|(sts_q & en_q)) |=> irq_o);
    p_irq_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(sts_q & en_q)) |=> !irq_o);
endmodule

bind dualrole_csr dualrole_csr_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .line_i    (line_i),
    .evt_i     (evt_i),
    .hnp_clr_i (hnp_clr_i),
    .ctl_o     (ctl_o),
    .irq_o     (irq_o),
    .sts_q     (sts_q),
    .en_q      (en_q)
);

// File: tb/dualrole_csr_tb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference updated each edge, compared every cycle,
// plus directed checks per requirement.
module dualrole_csr_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = 5'h0C;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [4:0]  line_i = 5'b10101;
    logic        overcur_i = 1'b0, as_peri_i = 1'b0, as_host_i = 1'b0;
    logic [7:0]  evt_i = '0;
    logic        hnp_clr_i = 1'b0;
    logic [5:0]  ctl_o, phy_o;
    logic        irq_o;

    int errors = 0;
    int checks = 0;

    always #10 clk = ~clk;

    dualrole_csr dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_i(line_i),
        .overcur_i(overcur_i), .as_peri_i(as_peri_i), .as_host_i(as_host_i),
        .evt_i(evt_i), .hnp_clr_i(hnp_clr_i), .ctl_o(ctl_o), .phy_o(phy_o),
        .irq_o(irq_o)
    );

    // reference model state
    int unsigned m_ctl, m_phy, m_en, m_sts, m_irq, m_prev;
    int evt_bit  [8] = '{0, 1, 2, 3, 4, 6, 7, 13};
    int line_bit [5] = '{5, 11, 8, 9, 10};

    always @(posedge clk) begin
        int unsigned setv, clrv;
        if (!rst_n) begin
            m_ctl = 0; m_phy = 0; m_en = 0; m_sts = 0; m_irq = 0;
        end else begin
            m_irq = ((m_sts & m_en) != 0) ? 1 : 0;
            setv = 0;
            for (int i = 0; i < 5; i++)
                if (line_i[i] != m_prev[i]) setv = setv | (1 << line_bit[i]);
            for (int i = 0; i < 8; i++)
                if (evt_i[i]) setv = setv | (1 << evt_bit[i]);
            clrv = (bus_we && bus_addr == 5'h0C) ? bus_wdata : 0;
            m_sts = ((m_sts & ~clrv) | setv) & 32'h2FFF;
            if (bus_we && bus_addr == 5'h00) begin
                m_ctl = bus_wdata & 32'h37;
                if (bus_wdata[0]) m_ctl = m_ctl & ~32'h2;
            end
            if (line_i[0] != m_prev[0]) m_ctl = m_ctl & ~32'h2;
            if (hnp_clr_i) m_ctl = m_ctl & ~32'h4;
            if (bus_we && bus_addr == 5'h04) m_phy = bus_wdata & 32'h33;
            if (bus_we && bus_addr == 5'h08) m_en = bus_wdata & 32'h2FFF;
        end
        m_prev = line_i;
    end

    function automatic int unsigned live_word();
        return {24'd0, as_host_i, as_peri_i, line_i, overcur_i};
    endfunction

    function automatic int unsigned exp_rd(input logic [4:0] a);
        case (a)
            5'h00:   return m_ctl;
            5'h04:   return m_phy;
            5'h08:   return m_en;
            5'h0C:   return m_sts;
            5'h10:   return live_word();
            default: return 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        string tag;
        check("R7 ctl_o", {26'd0, ctl_o}, m_ctl);
        check("R2 phy_o", {26'd0, phy_o}, m_phy);
        check("R10 irq_o", {31'd0, irq_o}, m_irq);
        case (bus_addr)
            5'h08:   tag = "R6 rdata";
            5'h0C:   tag = "R5 rdata";
            5'h10:   tag = "R11 rdata";
            default: tag = "R2 rdata";
        endcase
        check(tag, bus_rdata, exp_rd(bus_addr));
    endtask

    task automatic step();
        @(posedge clk);
        #4;
        compare_all();
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        step();
        bus_we = 1'b0; bus_wdata = '0; bus_addr = 5'h0C;
    endtask

    task automatic rd(input logic [4:0] a, input string req, input logic [31:0] exp);
        bus_addr = a;
        #1;
        check(req, bus_rdata, exp);
        bus_addr = 5'h0C;
        #1;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) step();
        check("R1 irq in reset", {31'd0, irq_o}, 0);
        rst_n = 1'b1;
        step(); step();
        // R1: all zero, no spurious change flag
        rd(5'h00, "R1 ctl", 0);
        rd(5'h04, "R1 phy", 0);
        rd(5'h08, "R1 ien", 0);
        rd(5'h0C, "R1 flags", 0);
        rd(5'h10, "R11 live", 32'h2A);
        // R6 / R2 masks
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, "R6 ien mask", 32'h2FFF);
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, "R2 phy mask", 32'h33);
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, "R7 drop+req", 32'h35);
        wr(5'h00, 32'h16);
        rd(5'h00, "R2 ctl", 32'h16);
        wr(5'h14, 32'hFFFF_FFFF);
        rd(5'h14, "R2 unmapped", 0);
        wr(5'h10, 32'hFFFF_FFFF);
        rd(5'h0C, "R2 live write ignored", 0);
        // R3: each line, both directions
        for (int i = 1; i < 5; i++) begin
            line_i[i] = ~line_i[i];
            step();
            rd(5'h0C, "R3 toggle", 32'(1) << line_bit[i]);
            step();
            check("R10 irq after flag", {31'd0, irq_o}, 1);
            wr(5'h0C, 32'hFFFF_FFFF);
            rd(5'h0C, "R5 w1c", 0);
            line_i[i] = ~line_i[i];
            step();
            rd(5'h0C, "R3 toggle back", 32'(1) << line_bit[i]);
            wr(5'h0C, 32'h0);
            rd(5'h0C, "R5 write 0 keeps", 32'(1) << line_bit[i]);
            wr(5'h0C, 32'(1) << line_bit[i]);
        end
        // R8: ID toggle clears bus request, beats a same-cycle write
        line_i[0] = ~line_i[0];
        bus_addr = 5'h00; bus_we = 1'b1; bus_wdata = 32'h16;
        step();
        bus_we = 1'b0; bus_addr = 5'h0C;
        rd(5'h00, "R8 id clears busreq", 32'h14);
        rd(5'h0C, "R3 id flag", 32'h20);
        wr(5'h0C, 32'hFFFF_FFFF);
        // R4: all events
        evt_i = 8'hFF;
        step();
        evt_i = 8'h00;
        rd(5'h0C, "R4 events", 32'h20DF);
        // R5: set beats clear on the same edge
        evt_i = 8'h01;
        wr(5'h0C, 32'h1);
        evt_i = 8'h00;
        rd(5'h0C, "R5 set wins", 32'h20DF);
        wr(5'h0C, 32'h1);
        rd(5'h0C, "R5 w1c single", 32'h20DE);
        // R7
        wr(5'h00, 32'h16);
        wr(5'h00, 32'h03);
        rd(5'h00, "R7 drop clears busreq", 32'h01);
        // R9
        wr(5'h00, 32'h16);
        hnp_clr_i = 1'b1;
        step();
        rd(5'h00, "R9 hnp clear", 32'h12);
        wr(5'h00, 32'h16);
        hnp_clr_i = 1'b0;
        rd(5'h00, "R9 hnp clear beats write", 32'h12);
        // R10: masking
        wr(5'h08, 32'h0);
        step();
        check("R10 irq masked", {31'd0, irq_o}, 0);
        wr(5'h08, 32'h2000);
        step();
        check("R10 irq enabled", {31'd0, irq_o}, 1);
        wr(5'h0C, 32'h2000);
        step();
        check("R10 irq after clear", {31'd0, irq_o}, 0);
        // R11: live inputs
        overcur_i = 1'b1; as_host_i = 1'b1; line_i = 5'b01010;
        #1;
        rd(5'h10, "R11 live", {24'd0, 1'b1, 1'b0, 5'b01010, 1'b1});
        step(); step();
        as_peri_i = 1'b1; as_host_i = 1'b0; overcur_i = 1'b0;
        rd(5'h10, "R11 live peri", {24'd0, 1'b0, 1'b1, 5'b01010, 1'b0});
        step();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule